// File: doc/BRIEF.md
# SGRAM Column Burst Engine with Burst Stop

This block models the device side of the column burst path in a two-bank synchronous graphics DRAM. On every rising clock edge it decodes the active-low command pins (chip select, row strobe, column strobe, write enable) together with a special-function pin. It opens a read or write burst at the addressed bank and column and steps the column address each cycle. Read data is returned through a delay line whose depth is the programmed CAS latency. Write data is sampled into a small internal column array in the same cycle as each write beat.

A burst-stop command cuts off a running burst of any length, including full page. On a read, the beats that are already in the latency pipeline still come out, and none follow them. On a write, the data on the stop cycle and after it is discarded. A burst opened with auto precharge ignores the stop. A read or write that arrives while a burst is open replaces that burst. Clock enable low freezes the whole engine.

Top module: `sgram_burst_engine`

## Requirements
- R1: With chip select low and the row strobe high, the pins {cas_ni, we_ni, dsf_i} = 010 decode as read, 000 as write and 100 as burst stop. Every other pattern, including any with the row strobe low, is a no-op.
- R2: When cs_ni is high, all other command and address pins are ignored and the cycle acts as a no-op. An open burst keeps running.
- R3: A beat issued at clock edge k (edge 0 is the command edge) is visible on dq_o with dq_valid_o high right after edge k+L-1, where L is cas_lat_i (1, 2 or 3). It can therefore be captured at edge k+L.
- R4: burst_len_i codes 0, 1, 2 and 3 give fixed bursts of 1, 2, 4 and 8 beats. Beat j addresses column (start & ~(n-1)) | ((start+j) & (n-1)), which wraps inside the aligned block of n columns.
- R5: burst_len_i code 7 selects full page. The column steps by one and wraps from 15 to 0 for as long as the burst is open.
- R6: A burst stop at edge s on a read without auto precharge leaves exactly the beats issued at edges 0 to s-1. The last of them appears after edge s+L-2, and no further valid beat follows.
- R7: A burst stop at edge s on a write without auto precharge writes the data of edges 0 to s-1 only. The data on edge s and on later edges is not stored.
- R8: ap_i high with a read or write command makes a later burst stop have no effect on that burst, which runs to its full length.
- R9: A read or write command during an open burst ends the old burst at that edge and starts the new one. Read beats already in the latency pipeline are still delivered, back to back with the new burst.
- R10: While cke_i is low, no command is taken, the burst does not advance, nothing is written, and dq_o and dq_valid_o hold their values.
- R11: After reset, dq_valid_o is low, dq_o is zero and no burst is open.
- R12: dq_o is zero in every cycle in which dq_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; low freezes the engine |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| dsf_i | input | 1 | Special-function pin, must be low for read, write and stop |
| ba_i | input | BA_W | Bank select |
| col_i | input | COL_W | Start column |
| ap_i | input | 1 | Auto precharge flag sampled with read or write |
| cas_lat_i | input | CL_W | CAS latency, 1 to 3 |
| burst_len_i | input | 3 | Burst length code |
| dq_i | input | DATA_W | Write data |
| dq_o | output | DATA_W | Read data |
| dq_valid_o | output | 1 | High exactly in cycles carrying read data |

## Verification
The bench sweeps every CAS latency against every burst length, several start columns and several stop positions. It checks the exact beat count and the beat timing after a stop. An engine that cut a stopped read one cycle early, or let one extra beat through, would show a wrong beat count. The initial fill writes a full page with a stop one beat after the last column. A design that failed to mask the stop cycle would overwrite column 0, and the read-back would catch it. Further cases cover a stop while chip select is high or with the special-function pin high, a stop against an auto-precharge burst, a read that interrupts another read, and clock enable dropping in the middle of a burst. A design that took any of these commands, or let the burst advance while frozen, would produce a shifted or truncated beat stream.

// File: rtl/sgram_pkg.sv
package sgram_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_STOP  = 2'd3
  } cmd_e;
endpackage

// File: rtl/sgram_cmd_decode.sv
module sgram_cmd_decode
  import sgram_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic dsf_i,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni && ras_ni) begin
      unique case ({cas_ni, we_ni, dsf_i})
        3'b010:  cmd_o = CMD_READ;
        3'b000:  cmd_o = CMD_WRITE;
        3'b100:  cmd_o = CMD_STOP;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sgram_burst_ctrl.sv
module sgram_burst_ctrl
  import sgram_pkg::*;
#(
  parameter int COL_W = 4,
  parameter int BA_W  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  cmd_e             cmd_i,
  input  logic [BA_W-1:0]  ba_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             ap_i,
  input  logic [2:0]       bl_i,
  output logic             beat_vld_o,
  output logic             beat_wr_o,
  output logic [BA_W-1:0]  beat_ba_o,
  output logic [COL_W-1:0] beat_col_o,
  output logic             act_o,
  output logic             ap_o
);
  localparam int CNT_W = COL_W + 1;

  logic             act_q, wr_q, ap_q, full_q;
  logic [BA_W-1:0]  ba_q;
  logic [COL_W-1:0] col_q, mask_q;
  logic [CNT_W-1:0] rem_q;

  logic             new_c, full_c, stop_hit;
  logic [COL_W-1:0] mask_c;
  logic [CNT_W-1:0] len_c;

  function automatic logic [COL_W-1:0] next_col(input logic [COL_W-1:0] c,
                                                input logic [COL_W-1:0] m);
    return (c & ~m) | ((c + COL_W'(1)) & m);
  endfunction

  always_comb begin
    new_c    = (cmd_i == CMD_READ) || (cmd_i == CMD_WRITE);
    full_c   = bl_i[2];
    len_c    = CNT_W'(1) << bl_i[1:0];
    mask_c   = full_c ? '1 : COL_W'(len_c - CNT_W'(1));
    stop_hit = (cmd_i == CMD_STOP) && act_q && !ap_q;
  end

  // first beat issues in the command cycle itself
  assign beat_vld_o = new_c || (act_q && !stop_hit);
  assign beat_wr_o  = new_c ? (cmd_i == CMD_WRITE) : wr_q;
  assign beat_ba_o  = new_c ? ba_i : ba_q;
  assign beat_col_o = new_c ? col_i : col_q;
  assign act_o      = act_q;
  assign ap_o       = ap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      ap_q   <= 1'b0;
      full_q <= 1'b0;
      ba_q   <= '0;
      col_q  <= '0;
      mask_q <= '0;
      rem_q  <= '0;
    end else if (en_i) begin
      if (new_c) begin
        act_q  <= full_c || (bl_i[1:0] != 2'd0);
        wr_q   <= (cmd_i == CMD_WRITE);
        ap_q   <= ap_i;
        full_q <= full_c;
        ba_q   <= ba_i;
        col_q  <= next_col(col_i, mask_c);
        mask_q <= mask_c;
        rem_q  <= len_c - CNT_W'(1);
      end else if (stop_hit) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        col_q <= next_col(col_q, mask_q);
        if (!full_q) begin
          rem_q <= rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) act_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sgram_rd_pipe.sv
module sgram_rd_pipe #(
  parameter int DATA_W  = 8,
  parameter int MAX_LAT = 3,
  parameter int LAT_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LAT_W-1:0]  lat_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);
  logic              vld_q [MAX_LAT];
  logic [DATA_W-1:0] dat_q [MAX_LAT];
  logic [LAT_W-1:0]  sel;

  for (genvar i = 0; i < MAX_LAT; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[0] <= 1'b0;
          dat_q[0] <= '0;
        end else if (en_i) begin
          vld_q[0] <= vld_i;
          dat_q[0] <= vld_i ? data_i : '0;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[i] <= 1'b0;
          dat_q[i] <= '0;
        end else if (en_i) begin
          vld_q[i] <= vld_q[i-1];
          dat_q[i] <= dat_q[i-1];
        end
      end
    end
  end

  always_comb begin
    if (lat_i == '0)                   sel = '0;
    else if (lat_i > LAT_W'(MAX_LAT))  sel = LAT_W'(MAX_LAT - 1);
    else                               sel = lat_i - LAT_W'(1);
    vld_o  = vld_q[sel];
    data_o = dat_q[sel];
  end
endmodule

// File: rtl/sgram_col_array.sv
module sgram_col_array #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/sgram_burst_engine.sv
module sgram_burst_engine
  import sgram_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COL_W  = 4,
  parameter int BA_W   = 1,
  parameter int MAX_CL = 3,
  localparam int CL_W  = $clog2(MAX_CL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              dsf_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  input  logic [CL_W-1:0]   cas_lat_i,
  input  logic [2:0]        burst_len_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_valid_o
);
  localparam int ADDR_W = BA_W + COL_W;

  cmd_e              cmd;
  logic              beat_vld, beat_wr, burst_act, burst_ap, mem_we;
  logic [BA_W-1:0]   beat_ba;
  logic [COL_W-1:0]  beat_col;
  logic [DATA_W-1:0] rdata;

  sgram_cmd_decode u_dec (
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .dsf_i  (dsf_i),
    .cmd_o  (cmd)
  );

  sgram_burst_ctrl #(.COL_W(COL_W), .BA_W(BA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cke_i),
    .cmd_i      (cmd),
    .ba_i       (ba_i),
    .col_i      (col_i),
    .ap_i       (ap_i),
    .bl_i       (burst_len_i),
    .beat_vld_o (beat_vld),
    .beat_wr_o  (beat_wr),
    .beat_ba_o  (beat_ba),
    .beat_col_o (beat_col),
    .act_o      (burst_act),
    .ap_o       (burst_ap)
  );

  assign mem_we = cke_i && beat_vld && beat_wr;

  sgram_col_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .addr_i  ({beat_ba, beat_col}),
    .wdata_i (dq_i),
    .rdata_o (rdata)
  );

  sgram_rd_pipe #(.DATA_W(DATA_W), .MAX_LAT(MAX_CL), .LAT_W(CL_W)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cke_i),
    .vld_i  (beat_vld && !beat_wr),
    .data_i (rdata),
    .lat_i  (cas_lat_i),
    .vld_o  (dq_valid_o),
    .data_o (dq_o)
  );
endmodule

// File: rtl/sgram_burst_engine_chk.sv
module sgram_burst_engine_chk
  import sgram_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CL_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_i,
  input logic              cs_ni,
  input logic [CL_W-1:0]   cas_lat_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_valid_o,
  input cmd_e              cmd,
  input logic              burst_act,
  input logic              burst_ap,
  input logic              beat_vld,
  input logic              mem_we
);
  a_r2_deselect_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && cs_ni && !burst_act |=> !burst_act);

  a_r3_latency_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && cmd == CMD_READ && cas_lat_i == CL_W'(1) |=> dq_valid_o);

  a_r6_stop_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && cmd == CMD_STOP && burst_act && !burst_ap |=> !burst_act);

  a_r7_stop_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_STOP && burst_act && !burst_ap |-> !mem_we);

  a_r8_ap_keeps_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_STOP && burst_act && burst_ap |-> beat_vld);

  a_r10_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> $stable(dq_o) && $stable(dq_valid_o));

  a_r12_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_valid_o |-> dq_o == '0);
endmodule

bind sgram_burst_engine sgram_burst_engine_chk #(.DATA_W(DATA_W), .CL_W(CL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cke_i      (cke_i),
  .cs_ni      (cs_ni),
  .cas_lat_i  (cas_lat_i),
  .dq_o       (dq_o),
  .dq_valid_o (dq_valid_o),
  .cmd        (cmd),
  .burst_act  (burst_act),
  .burst_ap   (burst_ap),
  .beat_vld   (beat_vld),
  .mem_we     (mem_we)
);

// File: tb/sgram_burst_engine_tb.sv
`timescale 1ns/1ps
module sgram_burst_engine_tb;
  localparam int K_NOP = 0, K_RD = 1, K_WR = 2, K_STOP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
  logic       ba = 1'b0, ap = 1'b0;
  logic [3:0] col = '0;
  logic [1:0] cl = 2'd1;
  logic [2:0] bl = 3'd0;
  logic [7:0] dq_in = '0;
  logic [7:0] dq_out;
  logic       dq_vld;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [7:0] model [32];

  always #2.5 clk = ~clk;

  sgram_burst_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .dsf_i(dsf), .ba_i(ba), .col_i(col), .ap_i(ap),
    .cas_lat_i(cl), .burst_len_i(bl), .dq_i(dq_in), .dq_o(dq_out), .dq_valid_o(dq_vld)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input int kind, input logic b, input logic [3:0] c,
                       input logic a, input logic cs, input logic d);
    cs_n = cs; dsf = d; ba = b; col = c; ap = a;
    case (kind)
      K_RD:    begin ras_n = 1; cas_n = 0; we_n = 1; end
      K_WR:    begin ras_n = 1; cas_n = 0; we_n = 0; end
      K_STOP:  begin ras_n = 1; cas_n = 1; we_n = 0; end
      default: begin ras_n = 1; cas_n = 1; we_n = 1; end
    endcase
  endtask

  function automatic int addr(input int start, input int j, input int code);
    int m = (code >= 4) ? 15 : (1 << code) - 1;
    return (start & ~m) | ((start + j) & m);
  endfunction

  function automatic int blen(input int code);
    return (code >= 4) ? 1000 : (1 << code);
  endfunction

  // kind: 0 stop, 1 stop while deselected, 2 stop with dsf high, 3 interrupting read
  task automatic run_read(input logic b, input int c, input int code, input int lat,
                          input int stop_at, input int kind, input logic apf, input string req);
    int len = blen(code);
    int n1;
    if (kind == 1 || kind == 2 || stop_at == 0 || (kind == 0 && apf)) n1 = len;
    else n1 = (stop_at < len) ? stop_at : len;
    @(negedge clk);
    cl = 2'(lat); bl = 3'(code);
    drive(K_RD, b, 4'(c), apf, 0, 0);
    for (int s = 0; s < 24; s++) begin
      int k;
      logic ev;
      logic [7:0] ed;
      @(posedge clk);
      @(negedge clk);
      k = s - (lat - 1);
      ev = 0; ed = 0;
      if (k >= 0 && k < n1) begin
        ev = 1; ed = model[b*16 + addr(c, k, code)];
      end else if (kind == 3 && k >= stop_at && k - stop_at < len) begin
        ev = 1; ed = model[(b ^ 1)*16 + addr(8, k - stop_at, code)];
      end
      chk({dq_vld, dq_out} == {ev, ed}, req, {dq_vld, dq_out}, {ev, ed});
      if (!ev) chk(dq_out == 0, "R12", {1'b0, dq_out}, 9'h0);
      if (stop_at != 0 && s + 1 == stop_at) begin
        case (kind)
          1:       drive(K_STOP, b, 4'(c), 0, 1, 0);
          2:       drive(K_STOP, b, 4'(c), 0, 0, 1);
          3:       drive(K_RD, b ^ 1'b1, 4'd8, 0, 0, 0);
          default: drive(K_STOP, b, 4'(c), 0, 0, 0);
        endcase
      end else drive(K_NOP, 0, 0, 0, 0, 0);
    end
  endtask

  task automatic run_write(input logic b, input int c, input int code, input int stop_at,
                           input logic apf, input logic [7:0] seed);
    int len = blen(code);
    int n = (stop_at != 0 && !apf) ? ((stop_at < len) ? stop_at : len) : len;
    @(negedge clk);
    bl = 3'(code);
    drive(K_WR, b, 4'(c), apf, 0, 0);
    dq_in = seed;
    for (int s = 0; s < 20; s++) begin
      @(posedge clk);
      @(negedge clk);
      dq_in = seed + 8'(s + 1);
      if (stop_at != 0 && s + 1 == stop_at) drive(K_STOP, b, 4'(c), 0, 0, 0);
      else drive(K_NOP, 0, 0, 0, 0, 0);
    end
    for (int k = 0; k < n; k++) model[b*16 + addr(c, k, code)] = seed + 8'(k);
  endtask

  initial begin
    int codes [5] = '{0, 1, 2, 3, 7};
    int cols [3] = '{0, 5, 13};
    int stops [3] = '{0, 1, 3};
    drive(K_NOP, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({dq_vld, dq_out} == 9'h0, "R11", {dq_vld, dq_out}, 9'h0);
    rst_n = 1;
    @(negedge clk);
    chk({dq_vld, dq_out} == 9'h0, "R11", {dq_vld, dq_out}, 9'h0);

    // fill both banks: full page, stop one beat past column 15 (R7 at wrap)
    run_write(0, 0, 7, 16, 0, 8'h40);
    run_write(1, 0, 7, 16, 0, 8'h80);
    run_read(0, 0, 7, 1, 16, 0, 0, "R7");
    run_read(1, 0, 7, 1, 16, 0, 0, "R7");

    // sweep latency x length x start column x stop position (R3 R4 R5 R6)
    for (int li = 1; li <= 3; li++)
      for (int ci = 0; ci < 5; ci++)
        for (int si = 0; si < 3; si++)
          for (int st = 0; st < 3; st++) begin
            int sa = stops[st];
            if (codes[ci] == 7 && sa == 0) sa = 20;
            run_read(1'(si & 1), cols[si], codes[ci], li, sa, 0, 0,
                     codes[ci] == 7 ? "R5" : (sa == 0 ? "R4" : "R6"));
          end

    for (int li = 1; li <= 3; li++) begin
      run_read(0, 2, 3, li, 2, 0, 1, "R8");
      run_read(1, 4, 2, li, 2, 1, 0, "R2");
      run_read(0, 6, 2, li, 2, 2, 0, "R1");
      run_read(0, 1, 3, li, 3, 3, 0, "R9");
    end

    // write stop mid burst and auto precharge write (R7 R8)
    run_write(0, 3, 3, 2, 0, 8'hC0);
    run_read(0, 0, 7, 2, 16, 0, 0, "R7");
    run_write(1, 4, 2, 1, 1, 8'hE0);
    run_read(1, 0, 7, 3, 16, 0, 0, "R8");

    // clock enable low mid burst, stop offered while frozen (R10)
    @(negedge clk);
    cl = 2'd1; bl = 3'd2;
    drive(K_RD, 0, 0, 0, 0, 0);
    @(posedge clk); @(negedge clk);
    chk({dq_vld, dq_out} == {1'b1, model[0]}, "R10", {dq_vld, dq_out}, {1'b1, model[0]});
    cke = 0;
    drive(K_STOP, 0, 0, 0, 0, 0);
    @(posedge clk); @(negedge clk);
    chk({dq_vld, dq_out} == {1'b1, model[0]}, "R10", {dq_vld, dq_out}, {1'b1, model[0]});
    cke = 1;
    drive(K_NOP, 0, 0, 0, 0, 0);
    for (int k = 1; k <= 4; k++) begin
      logic [8:0] e;
      @(posedge clk); @(negedge clk);
      e = (k < 4) ? {1'b1, model[k]} : 9'h0;
      chk({dq_vld, dq_out} == e, "R10", {dq_vld, dq_out}, e);
    end

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      report();
    end
  end
endmodule